// File: doc/BRIEF.md
# CORDIC Rotation Element with Paired Accumulators

This block is one element of a linear array that computes a family of real orthogonal transforms: cosine, sine and Hartley, and their inverses. It holds an iterative CORDIC rotator and two accumulators. A block of NPTS macro-rotations is fed to it one at a time. Each macro-rotation turns a short vector through the angle given by a set of per-step direction bits. The element sums the rotated components so that, once the block ends, it holds a transform point and that point's mirror at the same time.

For each block, a format field chooses how one input sample becomes a vector. A mode bit chooses how the second accumulator works: it either sums the rotated y component, or it adds the rotated x component on even rotations and subtracts it on odd ones. Both are captured on the first rotation of a block. When the block ends, the sums move in a single cycle into a pair of result registers. The accumulators are then free for the next block, while the previous results stay readable. Scaling by the CORDIC gain and by the transform constants is left to logic downstream.

Top module: `cordic_dual_acc_pe`

## Requirements
- R1: While reset is held and just after it, `in_ready` is 1, `res_valid` is 0 and both result outputs are 0.
- R2: A sample d becomes a vector chosen by `cfg_fmt`: 2'b00 gives (d, 0), 2'b01 gives (d, d), 2'b10 gives (0, d), and 2'b11 behaves like 2'b00.
- R3: A macro-rotation is ITER micro-steps, where step i uses shift i and direction bit `in_dir[i]`. With the bit at 0 the step computes x' = x - (y >>> i) and y' = y + (x >>> i). With the bit at 1 it computes x' = x + (y >>> i) and y' = y - (x >>> i). The shifts are arithmetic.
- R4: A rotation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays low for exactly ITER cycles. `in_valid` has no effect while `in_ready` is low.
- R5: `res_fwd` is the sum of the rotated x components of the NPTS rotations in a block.
- R6: With the mode bit at 0, `res_mir` is the sum of the rotated y components.
- R7: With the mode bit at 1, `res_mir` adds the rotated x component when `in_odd` is 0 and subtracts it when `in_odd` is 1.
- R8: The mode bit and the format are sampled only when the first rotation of a block is accepted. Changes to them later in the block have no effect.
- R9: Each block starts from zero, so back-to-back blocks give independent results.
- R10: `res_valid` is a one-cycle pulse. It rises ITER cycles after the NPTS-th rotation is accepted, and the new results appear in the same cycle.
- R11: The result outputs hold their values between pulses, including while the next block is being computed.
- R12: The rotator is DW+2 bits wide and the accumulators have log2(NPTS) more bits, so full-scale samples of either sign do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_alt | input | 1 | Second-accumulator mode, sampled at block start |
| cfg_fmt | input | 2 | Input vector format, sampled at block start |
| in_valid | input | 1 | Rotation request |
| in_ready | output | 1 | Rotator idle |
| in_data | input | DW | Signed input sample |
| in_dir | input | ITER | Micro-step direction bits |
| in_odd | input | 1 | Parity of the rotation index |
| res_valid | output | 1 | One-cycle result pulse |
| res_fwd | output | DW+2+log2(NPTS) | Signed point result |
| res_mir | output | DW+2+log2(NPTS) | Signed mirror-point result |

## Verification
The properties assume that a block always has at least two rotations, so that two result pulses can never be adjacent. They also assume that result registers change only when a block completes. Requests arriving while the rotator is busy are taken to be harmless, not absent. For that reason the stimulus deliberately raises `in_valid` with altered data in the middle of each rotation, and the expected sums must still come out as if those requests had never happened. Samples stay within DW signed bits, including both full-scale extremes with all steps turning the same way, which keeps every value inside the headroom that R12 promises.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    FMT_COS   = 2'b00,
    FMT_HART  = 2'b01,
    FMT_SINE  = 2'b10,
    FMT_SPARE = 2'b11
  } vec_fmt_e;
endpackage

// File: rtl/pe_rotator.sv
module pe_rotator #(
  parameter int RW   = 14,
  parameter int ITER = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [RW-1:0] x_in,
  input  logic signed [RW-1:0] y_in,
  input  logic [ITER-1:0]      dir_in,
  output logic                 busy,
  output logic                 last,
  output logic signed [RW-1:0] x_next,
  output logic signed [RW-1:0] y_next
);
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;

  logic signed [RW-1:0] x_q, y_q, x_d, y_d, xs, ys;
  logic [ITER-1:0]      dir_q, dir_d;
  logic [IW-1:0]        cnt_q, cnt_d;
  logic                 busy_q, busy_d, en;

  // one micro-step using the current step index as the shift
  always_comb begin
    xs = x_q >>> cnt_q;
    ys = y_q >>> cnt_q;
    if (dir_q[cnt_q]) begin
      x_next = x_q + ys;
      y_next = y_q - xs;
    end else begin
      x_next = x_q - ys;
      y_next = y_q + xs;
    end
  end

  assign last = busy_q && (cnt_q == IW'(ITER - 1));
  assign busy = busy_q;
  assign en   = start || busy_q;

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    dir_d  = dir_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      x_d = x_next;
      y_d = y_next;
      if (last) begin
        cnt_d  = '0;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + IW'(1);
      end
    end else if (start) begin
      x_d    = x_in;
      y_d    = y_in;
      dir_d  = dir_in;
      cnt_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      dir_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      x_q    <= x_d;
      y_q    <= y_d;
      dir_q  <= dir_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/pe_dual_accum.sv
module pe_dual_accum #(
  parameter int RW = 14,
  parameter int AW = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 restart,
  input  logic                 alt_mode,
  input  logic                 odd,
  input  logic signed [RW-1:0] rx,
  input  logic signed [RW-1:0] ry,
  output logic signed [AW-1:0] sum1,
  output logic signed [AW-1:0] sum2
);
  logic signed [AW-1:0] acc1_q, acc2_q, rx_e, ry_e, base1, base2, term2;

  assign rx_e = {{(AW-RW){rx[RW-1]}}, rx};
  assign ry_e = {{(AW-RW){ry[RW-1]}}, ry};

  always_comb begin
    base1 = restart ? '0 : acc1_q;
    base2 = restart ? '0 : acc2_q;
    if (alt_mode) term2 = odd ? -rx_e : rx_e;
    else          term2 = ry_e;
    sum1 = base1 + rx_e;
    sum2 = base2 + term2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1_q <= '0;
      acc2_q <= '0;
    end else if (acc_en) begin
      acc1_q <= sum1;
      acc2_q <= sum2;
    end
  end
endmodule

// File: rtl/pe_result_buf.sv
module pe_result_buf #(
  parameter int AW = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [AW-1:0] d1,
  input  logic signed [AW-1:0] d2,
  output logic signed [AW-1:0] q1,
  output logic signed [AW-1:0] q2,
  output logic                 vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= '0;
      q2 <= '0;
    end else if (load) begin
      q1 <= d1;
      q2 <= d2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= load;
  end
endmodule

// File: rtl/cordic_dual_acc_pe.sv
module cordic_dual_acc_pe
  import pe_pkg::*;
#(
  parameter int  DW   = 12,
  parameter int  NPTS = 8,
  parameter int  ITER = 12,
  localparam int RW   = DW + 2,
  localparam int CW   = (NPTS > 1) ? $clog2(NPTS) : 1,
  localparam int AW   = RW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_alt,
  input  logic [1:0]           cfg_fmt,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  input  logic [ITER-1:0]      in_dir,
  input  logic                 in_odd,
  output logic                 res_valid,
  output logic signed [AW-1:0] res_fwd,
  output logic signed [AW-1:0] res_mir
);
  // reset asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic                 busy, rot_last, accept, blk_first, blk_last;
  logic signed [RW-1:0] vx, vy, rx, ry, ext;
  logic signed [AW-1:0] sum1, sum2;
  vec_fmt_e             fmt_q, fmt_d, eff_fmt;
  logic                 mode_q, mode_d, odd_q, odd_d;
  logic [CW-1:0]        rcnt_q, rcnt_d;

  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready;
  assign blk_first = (rcnt_q == '0);
  assign blk_last  = (rcnt_q == CW'(NPTS - 1));
  assign eff_fmt   = blk_first ? vec_fmt_e'(cfg_fmt) : fmt_q;
  assign ext       = {{(RW-DW){in_data[DW-1]}}, in_data};

  always_comb begin
    case (eff_fmt)
      FMT_HART: begin vx = ext; vy = ext; end
      FMT_SINE: begin vx = '0;  vy = ext; end
      default:  begin vx = ext; vy = '0;  end
    endcase
  end

  // block sequencing: per-block config capture and rotation count
  always_comb begin
    fmt_d  = fmt_q;
    mode_d = mode_q;
    odd_d  = odd_q;
    rcnt_d = rcnt_q;
    if (accept) begin
      odd_d = in_odd;
      if (blk_first) begin
        fmt_d  = vec_fmt_e'(cfg_fmt);
        mode_d = cfg_alt;
      end
    end
    if (rot_last) rcnt_d = blk_last ? '0 : rcnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      fmt_q  <= FMT_COS;
      mode_q <= 1'b0;
      odd_q  <= 1'b0;
    end else if (accept) begin
      fmt_q  <= fmt_d;
      mode_q <= mode_d;
      odd_q  <= odd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)     rcnt_q <= '0;
    else if (rot_last) rcnt_q <= rcnt_d;
  end

  pe_rotator #(.RW(RW), .ITER(ITER)) u_rot (
    .clk    (clk),
    .rst_n  (rst_sync),
    .start  (accept),
    .x_in   (vx),
    .y_in   (vy),
    .dir_in (in_dir),
    .busy   (busy),
    .last   (rot_last),
    .x_next (rx),
    .y_next (ry)
  );

  pe_dual_accum #(.RW(RW), .AW(AW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_sync),
    .acc_en   (rot_last),
    .restart  (blk_first),
    .alt_mode (mode_q),
    .odd      (odd_q),
    .rx       (rx),
    .ry       (ry),
    .sum1     (sum1),
    .sum2     (sum2)
  );

  pe_result_buf #(.AW(AW)) u_res (
    .clk   (clk),
    .rst_n (rst_sync),
    .load  (rot_last && blk_last),
    .d1    (sum1),
    .d2    (sum2),
    .q1    (res_fwd),
    .q2    (res_mir),
    .vld   (res_valid)
  );
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int  DW   = 12,
  parameter int  NPTS = 8,
  parameter int  ITER = 12,
  localparam int AW   = DW + 2 + ((NPTS > 1) ? $clog2(NPTS) : 1),
  localparam int BW   = $clog2(ITER + 2)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 res_valid,
  input logic signed [AW-1:0] res_fwd,
  input logic signed [AW-1:0] res_mir
);
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_run <= '0;
    else if (in_ready) busy_run <= '0;
    else               busy_run <= busy_run + BW'(1);
  end

  // R4: an accepted request makes the rotator busy
  p_ready_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4: busy never lasts longer than one macro-rotation
  p_busy_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= BW'(ITER));

  // R10: the result strobe lasts a single cycle
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R10: results arrive as the rotator goes idle
  p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> in_ready);

  // R11: result registers change only with the strobe
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_fwd) && $stable(res_mir)));
endmodule

bind cordic_dual_acc_pe pe_checker #(.DW(DW), .NPTS(NPTS), .ITER(ITER)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_fwd   (res_fwd),
  .res_mir   (res_mir)
);

// File: tb/sim_cordic_dual_acc_pe.sv
`timescale 1ns/1ps
module sim_cordic_dual_acc_pe;
  localparam int DW   = 12;
  localparam int NPTS = 8;
  localparam int ITER = 12;
  localparam int AW   = DW + 2 + $clog2(NPTS);

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 cfg_alt;
  logic [1:0]           cfg_fmt;
  logic                 in_valid;
  logic                 in_ready;
  logic signed [DW-1:0] in_data;
  logic [ITER-1:0]      in_dir;
  logic                 in_odd;
  logic                 res_valid;
  logic signed [AW-1:0] res_fwd, res_mir;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int seed   = 32'h2F1B_3C07;
  bit have_prev = 0;
  longint prev1, prev2;

  always #4 clk = ~clk;

  cordic_dual_acc_pe #(.DW(DW), .NPTS(NPTS), .ITER(ITER)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_alt(cfg_alt), .cfg_fmt(cfg_fmt),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_dir(in_dir), .in_odd(in_odd), .res_valid(res_valid),
    .res_fwd(res_fwd), .res_mir(res_mir)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL R4 watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R3 step rule, applied to plain integers
  task automatic model(input int x0, input int y0, input logic [ITER-1:0] dir,
                       output int rx, output int ry);
    int x, y, xs, ys;
    x = x0; y = y0;
    for (int i = 0; i < ITER; i++) begin
      xs = x >>> i;
      ys = y >>> i;
      if (dir[i]) begin x = x + ys; y = y - xs; end
      else        begin x = x - ys; y = y + xs; end
    end
    rx = x; ry = y;
  endtask

  task automatic do_rot(input logic signed [DW-1:0] d, input logic [ITER-1:0] dir,
                        input logic odd, input bit fin, input longint e1,
                        input longint e2, input string tf, input string tm);
    bit busy_ok;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_dir = dir; in_odd = odd;
    busy_ok = 1'b1;
    for (int j = 1; j <= ITER; j++) begin
      @(negedge clk);
      if (j == 1) in_valid = 1'b0;
      if (in_ready) busy_ok = 1'b0;
      if (j == 3) begin   // request while busy must be ignored (R4)
        in_valid = 1'b1; in_data = ~d; in_dir = ~dir; in_odd = ~odd;
      end
      if (j == 4) in_valid = 1'b0;
    end
    chk(busy_ok, "R4", "in_ready low through rotation", !busy_ok, 1);
    @(negedge clk);
    chk(in_ready == 1'b1, "R4", "in_ready after ITER cycles", in_ready, 1);
    if (fin) begin
      chk(res_valid == 1'b1, "R10", "strobe after last rotation", res_valid, 1);
      chk(res_fwd == e1, tf, "res_fwd", res_fwd, e1);
      chk(res_mir == e2, tm, "res_mir", res_mir, e2);
    end else begin
      chk(res_valid == 1'b0, "R10", "no strobe mid block", res_valid, 0);
    end
  endtask

  task automatic run_block(input int fmt, input bit mode, input int pat,
                           input bit flip, input string tf, input string tm);
    longint e1, e2;
    int x0, y0, rx, ry, d;
    logic [ITER-1:0] dir;
    logic odd;
    e1 = 0; e2 = 0;
    for (int r = 0; r < NPTS; r++) begin
      if (r == 0) begin cfg_fmt = 2'(fmt); cfg_alt = mode; end
      if (r == 1 && flip) begin cfg_fmt = 2'(fmt ^ 2); cfg_alt = ~mode; end // R8
      seed = seed * 1103515245 + 12345;
      case (pat)
        1:       begin d = 2047;  dir = '0; end
        2:       begin d = -2048; dir = '0; end
        3:       begin d = (r % 2 == 0) ? (r * 255 + 7) : -(r * 255 + 7); dir = 12'hA5C; end
        default: begin d = int'($signed(seed[19:8])); dir = seed[31:20]; end
      endcase
      odd = r[0];
      case (fmt)
        1:       begin x0 = d; y0 = d; end
        2:       begin x0 = 0; y0 = d; end
        default: begin x0 = d; y0 = 0; end
      endcase
      model(x0, y0, dir, rx, ry);
      e1 += rx;
      e2 += mode ? (odd ? -rx : rx) : ry;
      if (r == 2 && have_prev) begin
        chk(res_fwd == prev1, "R11", "res_fwd held", res_fwd, prev1);
        chk(res_mir == prev2, "R11", "res_mir held", res_mir, prev2);
      end
      do_rot(DW'(d), dir, odd, r == NPTS - 1, e1, e2, tf, tm);
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R10", "strobe is one cycle", res_valid, 0);
    prev1 = e1; prev2 = e2; have_prev = 1;
  endtask

  initial begin
    rst_n = 1'b0; cfg_alt = 1'b0; cfg_fmt = 2'b00; in_valid = 1'b0;
    in_data = '0; in_dir = '0; in_odd = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
    chk(res_fwd == 0, "R1", "res_fwd in reset", res_fwd, 0);
    chk(res_mir == 0, "R1", "res_mir in reset", res_mir, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(res_valid == 1'b0 && res_fwd == 0, "R1", "idle after reset", res_fwd, 0);

    for (int fm = 0; fm < 4; fm++)
      for (int md = 0; md < 2; md++)
        run_block(fm, md[0], 0, 1'b0, "R2 R3 R5 R9",
                  md[0] ? "R2 R3 R7 R9" : "R2 R3 R6 R9");
    run_block(1, 1'b0, 1, 1'b0, "R12 R5", "R12 R6");
    run_block(1, 1'b1, 2, 1'b0, "R12 R5", "R12 R7");
    run_block(2, 1'b0, 2, 1'b0, "R12 R5", "R12 R6");
    run_block(2, 1'b1, 3, 1'b0, "R5 R9", "R7 R9");
    run_block(0, 1'b1, 0, 1'b1, "R8 R5", "R8 R7");
    run_block(1, 1'b0, 3, 1'b1, "R8 R5", "R8 R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule